// File: doc/BRIEF.md
# Dual-Context Byte DMA for a Parallel Peripheral Port

The engine moves a buffer of bytes between system memory and a byte-wide peripheral stream. It works in one direction at a time. Software describes each buffer in one of two descriptor words, called context A and context B. Each word carries the start address, the byte count and a "last" marker. While the engine drains one context, software may refill the other, so a long stream can run without gaps. Each context has its own completion interrupt. A context marked last also sends a terminal-count pulse to the peripheral once its final byte has moved.

Memory is reached one byte per request through a request/acknowledge port. The peripheral side is a valid/ready byte stream: outbound for memory-to-device and inbound for device-to-memory. A small register port exposes the two context words, a control/status word and a read-only diagnostic word. The diagnostic word shows the active context, the activity flag and the live count of bytes left.

Top module: `ppdma_engine`

## Requirements
- R1: Register 0 is context A and register 1 is context B. In each word, bits 31:0 are the byte start address, bits 43:32 the byte count and bit 63 the last marker. Both words read back as written.
- R2: When control bit 0 is 0, the bytes at start address, start+1, and so on are read from memory in ascending order and presented on the outbound stream, for any alignment of the start address. A count of 0 completes at once and moves no byte.
- R3: When control bit 0 is 1, bytes accepted on the inbound stream are written to memory at ascending addresses from the start address.
- R4: `dev_tc` pulses for one cycle, in the completion cycle of a context whose last marker is 1. It never pulses for a context whose marker is 0.
- R5: Completion of context A pulses `irq_a` for one cycle, and completion of context B pulses `irq_b`. The completing context's valid flag (control bit 4 for A, bit 3 for B) reads 0 afterwards.
- R6: After reset or a channel reset, the engine serves context A first. When A completes and B is valid, B runs next. Diagnostic bit 0 reads 1 while B is in use.
- R7: Clearing control bit 1 freezes the channel. No memory request and no stream handshake occur, and the remaining count holds. Setting the bit again resumes the transfer with no byte lost or repeated.
- R8: Writing 1 to control bit 2 clears the enable, direction, valid flags, error flag, remaining count and engine state, and selects context A. Bit 2 always reads 0, and no interrupt follows from the abandoned transfer.
- R9: A context is rejected without moving any byte or raising an interrupt in two cases: device-to-memory with a start address that is not 64-byte aligned, or a buffer whose address bits 11:0 plus its count exceed 4096. On rejection the engine sets sticky error bit 5 and clears the context's valid flag. Writing 1 to bit 5 clears the error. A buffer ending exactly on the 4 KiB line is accepted.
- R10: Diagnostic bit 1 is 1 only while the engine is enabled and moving a buffer. Diagnostic bits 13:2 give the bytes still to move, and the value falls as bytes go.
- R11: In control writes, bits 4 and 3 set the A and B valid flags when 1 and leave them unchanged when 0. Bits 0 and 1 are stored as written.
- R12: Out of reset, all strobes and pulses are 0, and the control and diagnostic words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 ctx A, 1 ctx B, 2 control, 3 diagnostic |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Request accepted / read data valid |
| mem_rdata | input | 8 | Read byte |
| dev_out_valid | output | 1 | Outbound byte valid |
| dev_out_data | output | 8 | Outbound byte |
| dev_out_ready | input | 1 | Peripheral accepts byte |
| dev_in_valid | input | 1 | Inbound byte valid |
| dev_in_data | input | 8 | Inbound byte |
| dev_in_ready | output | 1 | Engine accepts byte |
| dev_tc | output | 1 | Terminal-count pulse |
| irq_a | output | 1 | Context A completion pulse |
| irq_b | output | 1 | Context B completion pulse |

## Verification
A wrong address or count register shows within one byte time as a wrong byte on the stream or a write to the wrong memory location. The bench compares every moved byte against a pattern computed from the address. A wrong context selector shows up as the wrong interrupt line or a wrong diagnostic bit 0 on the next completion. A count that moves while frozen shows in the diagnostic word within one cycle of the freeze. Failures of the rejection checks show as a missing error bit or a stray interrupt within a few cycles of the control write.

// File: rtl/ppdma_engine.sv
module ppdma_engine #(
  parameter int AW            = 32,
  parameter int LW            = 12,
  parameter int PAGE_BITS     = 12,
  parameter int IN_ALIGN_BITS = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [63:0]   reg_wdata,
  output logic [63:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic          mem_ack,
  input  logic [7:0]    mem_rdata,
  output logic          dev_out_valid,
  output logic [7:0]    dev_out_data,
  input  logic          dev_out_ready,
  input  logic          dev_in_valid,
  input  logic [7:0]    dev_in_data,
  output logic          dev_in_ready,
  output logic          dev_tc,
  output logic          irq_a,
  output logic          irq_b
);
  localparam int PW = PAGE_BITS + 1;
  localparam logic [PW-1:0] PAGE_SIZE = PW'(1) << PAGE_BITS;
  localparam int LEN_LSB = 32;
  localparam int LAST_BIT = 63;
  localparam int DIAG_PAD = 64 - LW - 2;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_SEND, S_RECV, S_STORE, S_DONE} st_t;

  st_t            st_q;
  logic [63:0]    ctx_q [2];
  logic           dir_q, en_q, err_q, sel_q, xdir_q, last_q;
  logic [1:0]     vld_q;
  logic [AW-1:0]  addr_q;
  logic [LW-1:0]  cnt_q;
  logic [7:0]     byte_q;

  wire ctrl_wr  = reg_wr && reg_addr == 2'd2;
  wire chan_rst = ctrl_wr && reg_wdata[2];

  wire [AW-1:0] cur_base = ctx_q[sel_q][AW-1:0];
  wire [LW-1:0] cur_len  = ctx_q[sel_q][LEN_LSB +: LW];
  wire          cur_last = ctx_q[sel_q][LAST_BIT];

  wire misalign = dir_q && (|cur_base[IN_ALIGN_BITS-1:0]);
  wire crosses  = ({1'b0, cur_base[PAGE_BITS-1:0]} + PW'(cur_len)) > PAGE_SIZE;
  wire reject   = misalign || crosses;
  wire busy     = st_q == S_FETCH || st_q == S_SEND || st_q == S_RECV || st_q == S_STORE;
  wire done     = en_q && st_q == S_DONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      ctx_q[0] <= '0;
      ctx_q[1] <= '0;
      dir_q  <= 1'b0; en_q <= 1'b0; err_q <= 1'b0; sel_q <= 1'b0;
      xdir_q <= 1'b0; last_q <= 1'b0; vld_q <= 2'b00;
      addr_q <= '0; cnt_q <= '0; byte_q <= '0;
    end else if (chan_rst) begin
      st_q   <= S_IDLE;
      dir_q  <= 1'b0; en_q <= 1'b0; err_q <= 1'b0; sel_q <= 1'b0;
      vld_q  <= 2'b00; cnt_q <= '0;
    end else begin
      if (reg_wr && reg_addr == 2'd0) ctx_q[0] <= reg_wdata;
      if (reg_wr && reg_addr == 2'd1) ctx_q[1] <= reg_wdata;
      if (en_q) begin
        case (st_q)
          S_IDLE: begin
            if (vld_q[sel_q]) begin
              if (reject) begin
                err_q <= 1'b1;
                vld_q[sel_q] <= 1'b0;
                sel_q <= ~sel_q;
              end else begin
                addr_q <= cur_base;
                cnt_q  <= cur_len;
                xdir_q <= dir_q;
                last_q <= cur_last;
                st_q   <= (cur_len == '0) ? S_DONE : (dir_q ? S_RECV : S_FETCH);
              end
            end else if (vld_q[~sel_q]) begin
              sel_q <= ~sel_q;
            end
          end
          S_FETCH: if (mem_ack) begin
            byte_q <= mem_rdata;
            st_q   <= S_SEND;
          end
          S_RECV: if (dev_in_valid) begin
            byte_q <= dev_in_data;
            st_q   <= S_STORE;
          end
          S_SEND, S_STORE: if ((st_q == S_SEND && dev_out_ready) || (st_q == S_STORE && mem_ack)) begin
            addr_q <= addr_q + AW'(1);
            cnt_q  <= cnt_q - LW'(1);
            st_q   <= (cnt_q == LW'(1)) ? S_DONE : (xdir_q ? S_RECV : S_FETCH);
          end
          S_DONE: begin
            vld_q[sel_q] <= 1'b0;
            sel_q <= ~sel_q;
            st_q  <= S_IDLE;
          end
          default: st_q <= S_IDLE;
        endcase
      end
      if (ctrl_wr) begin
        dir_q <= reg_wdata[0];
        en_q  <= reg_wdata[1];
        if (reg_wdata[3]) vld_q[1] <= 1'b1;
        if (reg_wdata[4]) vld_q[0] <= 1'b1;
        if (reg_wdata[5]) err_q <= 1'b0;
      end
    end
  end

  assign mem_req       = en_q && (st_q == S_FETCH || st_q == S_STORE);
  assign mem_we        = st_q == S_STORE;
  assign mem_addr      = addr_q;
  assign mem_wdata     = byte_q;
  assign dev_out_valid = en_q && st_q == S_SEND;
  assign dev_out_data  = byte_q;
  assign dev_in_ready  = en_q && st_q == S_RECV;
  assign irq_a         = done && !sel_q;
  assign irq_b         = done && sel_q;
  assign dev_tc        = done && last_q;

  wire [63:0] ctrl_word = {58'd0, err_q, vld_q[0], vld_q[1], 1'b0, en_q, dir_q};
  wire [63:0] diag_word = {{DIAG_PAD{1'b0}}, cnt_q, en_q && busy, sel_q};

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = ctx_q[0];
      2'd1:    reg_rdata = ctx_q[1];
      2'd2:    reg_rdata = ctrl_word;
      default: reg_rdata = diag_word;
    endcase
  end

  a_r4_tc_only_at_completion: assert property (@(posedge clk) disable iff (!rst_n)
    dev_tc |-> (irq_a || irq_b));
  a_r5_single_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_a, irq_b}));
  a_r5_valid_a_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_a && !(ctrl_wr && (reg_wdata[4] || reg_wdata[2]))) |=> !vld_q[0]);
  a_r7_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !reg_wr) |=> ($stable(cnt_q) && $stable(addr_q) && $stable(st_q)));
  a_r10_busy_has_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt_q != '0);
  a_r8_reset_quiets: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> !(irq_a || irq_b || mem_req || dev_out_valid || dev_in_ready));
endmodule

// File: tb/ppdma_engine_tb.sv
module ppdma_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        dev_out_valid, dev_out_ready = 1'b1;
  logic [7:0]  dev_out_data;
  logic        dev_in_valid = 1'b1;
  logic [7:0]  in_seq = 8'h10;
  logic        dev_in_ready, dev_tc, irq_a, irq_b;

  ppdma_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .dev_out_valid(dev_out_valid),
    .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready),
    .dev_in_valid(dev_in_valid), .dev_in_data(in_seq),
    .dev_in_ready(dev_in_ready), .dev_tc(dev_tc), .irq_a(irq_a), .irq_b(irq_b));

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] + 8'h3C + {4'h0, a[11:8]};
  endfunction

  assign mem_ack   = mem_req;
  assign mem_rdata = pat(mem_addr);

  logic [7:0] wmem [4096];
  logic [7:0] rx [256];
  int rx_n = 0, irqa_n = 0, irqb_n = 0, tc_n = 0, req_n = 0, cyc = 0;
  int irqa_cyc = 0, irqb_cyc = 0, tc_cyc = 0;
  int tests = 0, fails = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req) req_n <= req_n + 1;
    if (mem_req && mem_we && mem_ack) wmem[mem_addr[11:0]] <= mem_wdata;
    if (dev_out_valid && dev_out_ready) begin
      rx[rx_n[7:0]] <= dev_out_data;
      rx_n <= rx_n + 1;
    end
    if (dev_in_valid && dev_in_ready) in_seq <= in_seq + 8'd1;
    if (irq_a) begin irqa_n <= irqa_n + 1; irqa_cyc <= cyc; end
    if (irq_b) begin irqb_n <= irqb_n + 1; irqb_cyc <= cyc; end
    if (dev_tc) begin tc_n <= tc_n + 1; tc_cyc <= cyc; end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_irqs(input int target);
    for (int i = 0; i < 3000 && (irqa_n + irqb_n) < target; i++) @(negedge clk);
  endtask

  function automatic logic [63:0] ctxw(input bit last, input logic [31:0] base, input logic [11:0] len);
    return {last, 19'd0, len, base};
  endfunction

  // {dir, last, base[31:0], len[11:0]}
  localparam logic [45:0] VEC [4] = '{
    {1'b0, 1'b1, 32'h0000_1003, 12'd5},
    {1'b0, 1'b0, 32'h0000_2FF0, 12'd16},
    {1'b1, 1'b1, 32'h0000_3040, 12'd7},
    {1'b0, 1'b1, 32'h0000_0100, 12'd0}
  };

  logic [63:0] v;

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check({mem_req, dev_out_valid, dev_in_ready, dev_tc, irq_a, irq_b} == 6'd0, "R12 strobes",
          {mem_req, dev_out_valid, dev_in_ready, dev_tc, irq_a, irq_b}, 0);
    rd(2'd2, v); check(v == 0, "R12 ctrl", v, 0);
    rd(2'd3, v); check(v == 0, "R12 diag", v, 0);

    // table walk: entries alternate A,B,A,B from reset
    for (int i = 0; i < 4; i++) begin
      automatic bit          d    = VEC[i][45];
      automatic bit          last = VEC[i][44];
      automatic logic [31:0] base = VEC[i][43:12];
      automatic logic [11:0] len  = VEC[i][11:0];
      automatic int ctx = i % 2;
      automatic int rx0 = rx_n, tc0 = tc_n, a0 = irqa_n, b0 = irqb_n;
      automatic logic [7:0] s0 = in_seq;
      wr(ctx[1:0], ctxw(last, base, len));
      rd(ctx[1:0], v);
      check(v == ctxw(last, base, len), "R1 readback", v, ctxw(last, base, len));
      wr(2'd2, {59'd0, ctx == 0, ctx == 1, 1'b0, 1'b1, d});
      wait_irqs(a0 + b0 + 1);
      @(negedge clk);
      check((ctx == 0 ? irqa_n - a0 : irqb_n - b0) == 1, "R5 own irq", irqa_n - a0, ctx);
      check(tc_n - tc0 == int'(last), "R4 tc count", tc_n - tc0, last);
      rd(2'd2, v);
      check(v[4:3] == 2'b00, "R5 valid cleared", v[4:3], 0);
      if (!d) begin
        check(rx_n - rx0 == int'(len), "R2 byte count", rx_n - rx0, len);
        for (int k = 0; k < int'(len); k++)
          check(rx[(rx0 + k) % 256] == pat(base + k), "R2 data", rx[(rx0 + k) % 256], pat(base + k));
      end else begin
        for (int k = 0; k < int'(len); k++)
          check(wmem[(base[11:0] + k) % 4096] == s0 + 8'(k), "R3 data",
                wmem[(base[11:0] + k) % 4096], s0 + 8'(k));
      end
    end

    // R6 ping-pong
    wr(2'd2, 64'h4);
    begin
      automatic int rx0 = rx_n, tc0 = tc_n, a0 = irqa_n, b0 = irqb_n;
      wr(2'd0, ctxw(1'b0, 32'h200, 12'd3));
      wr(2'd1, ctxw(1'b1, 32'h300, 12'd4));
      wr(2'd2, 64'h1A);
      wait_irqs(a0 + b0 + 1);
      check(irqa_n - a0 == 1 && irqb_n == b0, "R6 A first", irqa_n - a0, 1);
      @(negedge clk);
      rd(2'd3, v);
      check(v[0] == 1'b1 && v[1] == 1'b1, "R6 diag shows B", v[1:0], 3);
      wait_irqs(a0 + b0 + 2);
      @(negedge clk);
      check(irqb_n - b0 == 1 && irqb_cyc > irqa_cyc, "R6 B second", irqb_cyc, irqa_cyc);
      check(tc_n - tc0 == 1 && tc_cyc == irqb_cyc, "R4 tc with B", tc_cyc, irqb_cyc);
      for (int k = 0; k < 7; k++) begin
        automatic logic [31:0] a = (k < 3) ? 32'h200 + k : 32'h300 + k - 3;
        check(rx[(rx0 + k) % 256] == pat(a), "R6 order", rx[(rx0 + k) % 256], pat(a));
      end
    end

    // R7 freeze / R10 diag
    wr(2'd2, 64'h4);
    begin
      automatic int rx0 = rx_n, a0 = irqa_n;
      automatic int r1, q1;
      automatic logic [63:0] d1;
      wr(2'd0, ctxw(1'b0, 32'h400, 12'd20));
      wr(2'd2, 64'h12);
      repeat (6) @(negedge clk);
      rd(2'd3, v);
      check(v[1] == 1'b1 && v[13:2] < 12'd20 && v[13:2] > 12'd0, "R10 active count", v[13:0], 20);
      wr(2'd2, 64'h0);
      rd(2'd3, d1);
      r1 = rx_n; q1 = req_n;
      check(d1[1] == 1'b0, "R10 inactive when frozen", d1[1], 0);
      repeat (10) @(negedge clk);
      rd(2'd3, v);
      check(v[13:2] == d1[13:2], "R7 count held", v[13:2], d1[13:2]);
      check(rx_n == r1 && req_n == q1, "R7 no traffic", rx_n - r1 + req_n - q1, 0);
      wr(2'd2, 64'h2);
      wait_irqs(a0 + irqb_n + 1);
      check(rx_n - rx0 == 20, "R7 resume count", rx_n - rx0, 20);
      for (int k = 0; k < 20; k++)
        check(rx[(rx0 + k) % 256] == pat(32'h400 + k), "R7 resume data", rx[(rx0 + k) % 256], pat(32'h400 + k));
    end

    // R9 rejection
    wr(2'd2, 64'h4);
    begin
      automatic int a0 = irqa_n, b0 = irqb_n, q0 = req_n;
      wr(2'd0, ctxw(1'b1, 32'h4041, 12'd4));
      wr(2'd2, 64'h13);
      repeat (5) @(negedge clk);
      rd(2'd2, v);
      check(v[5] == 1'b1 && v[4] == 1'b0, "R9 misaligned input", v[5:3], 3'b100);
      check(irqa_n == a0 && req_n == q0 && tc_n == tc_n, "R9 no irq/traffic", irqa_n - a0, 0);
      wr(2'd2, 64'h22);
      rd(2'd2, v);
      check(v[5] == 1'b0, "R9 error cleared", v[5], 0);
      wr(2'd1, ctxw(1'b0, 32'h5FFF, 12'd2));
      wr(2'd2, 64'h0A);
      repeat (5) @(negedge clk);
      rd(2'd2, v);
      check(v[5] == 1'b1 && v[3] == 1'b0, "R9 page cross", v[5:3], 3'b100);
      check(irqb_n == b0 && req_n == q0, "R9 no irq B", irqb_n - b0, 0);
    end

    // R11 write-one-to-set valid
    wr(2'd2, 64'h4);
    wr(2'd2, 64'h18);
    wr(2'd2, 64'h01);
    rd(2'd2, v);
    check(v[4:0] == 5'b11001, "R11 valid sticky, dir stored", v[4:0], 5'b11001);

    // R8 channel reset mid-transfer
    wr(2'd2, 64'h4);
    begin
      automatic int a0, b0, r0;
      wr(2'd0, ctxw(1'b1, 32'h100, 12'd30));
      wr(2'd2, 64'h12);
      repeat (6) @(negedge clk);
      wr(2'd2, 64'h4);
      a0 = irqa_n; b0 = irqb_n; r0 = rx_n;
      rd(2'd2, v); check(v == 0, "R8 ctrl cleared", v, 0);
      rd(2'd3, v); check(v == 0, "R8 diag cleared", v, 0);
      repeat (20) @(negedge clk);
      check(irqa_n == a0 && irqb_n == b0 && rx_n == r0, "R8 abandoned quiet", rx_n - r0, 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule